// File: doc/BRIEF.md
# Amplitude-Keyed Infrared Carrier Generator and Period Window

This block covers the amplitude-keyed path of an infrared link. It runs on a 7.3728 MHz tick, about 135.6 ns, which is twice a 3.6864 MHz reference. On the transmit side it divides that reference by the divider value plus two to make the LED carrier. The carrier is on only while the transmit data line is low. When the data line is high, the carrier output stays low and the LEDs are dark.

On the receive side a raw edge line from the analog front end first passes through a two-stage synchronizer. The block then measures the ticks between successive rising edges. It reports carrier-present once two consecutive periods fall inside an acceptance window. The window bounds come from the same divider value and from a tolerance field. As the divider value sets the transmit frequency, it also moves the window that the receiver accepts.

The block uses a single clock, which is the 7.3728 MHz tick itself. The divider value and tolerance field are static inputs, supplied by a register that is outside this block. That register should reset the divider value to 5, which gives a carrier near 527 kHz.

Top module: `ask_carrier_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both carrier_o and carrier_ok_o are low.
- R2: carrier_o is low on every tick following a clock edge at which txd_i is sampled high.
- R3: With txd_i held low, carrier_o repeats with a period of 2·(md_i+2) ticks. It is high on the tick following the first edge at which txd_i is sampled low.
- R4: Within each carrier period, carrier_o is high for the first 2·ceil((md_i+2)/2) ticks and low for the rest. For an odd divisor, the high half is one reference count longer.
- R5: rx_edge_i passes through two synchronizer flops. A rising edge counts at clock edge k+2 when the input was sampled high at edge k and low at edge k-1.
- R6: A period is the number of ticks between two consecutive counted rising edges. A period is in window when it lies between 2·md_i+3+rats_i and 2·md_i+3+6·(rats_i+1), both bounds included.
- R7: After reset or a timeout, the first counted rising edge only starts timing. carrier_ok_o goes high on the tick after the edge that closes the second consecutive in-window period.
- R8: A counted rising edge that closes an out-of-window period clears carrier_ok_o on the next tick and restarts the count of in-window periods.
- R9: Timeout: once more than the maximum window period elapses with no counted rising edge, carrier_ok_o clears. The next counted edge then only restarts timing.
- R10: A period exactly equal to either window bound is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7.3728 MHz tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| md_i | input | MD_W | Modulator divider value |
| rats_i | input | RATS_W | Receive window tolerance field |
| txd_i | input | 1 | Transmit data, carrier sent while low |
| rx_edge_i | input | 1 | Raw receive pulse line, asynchronous |
| carrier_o | output | 1 | LED carrier drive |
| carrier_ok_o | output | 1 | Valid carrier present |

## Verification
carrier_o comes from a single register. It therefore reflects the txd_i and md_i values seen at an edge in the tick directly after that edge. carrier_ok_o reacts three edges after the raw line is sampled: two synchronizer edges, then one state edge.

The bench keeps a behavioural model indexed by clock edge. It delays raw samples by that latency and judges periods as differences of edge numbers. It compares both outputs at every falling edge, half a tick after the edge that sets them. Named checks are placed just after each pulse train ends, well inside the timeout span, so they see the lock state before silence clears it.

// File: rtl/ask_pkg.sv
`timescale 1ns/1ps
package ask_pkg;
    // Number of synchronizer flops ahead of the edge detector.
    localparam int SYNC_STAGES = 2;

    // Progress toward carrier lock.
    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_ONE  = 2'd1,
        HIT_LOCK = 2'd2
    } hit_e;
endpackage

// File: rtl/ask_tx_div.sv
`timescale 1ns/1ps
module ask_tx_div #(
    parameter int MD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [MD_W-1:0] md_i,
    input  logic            txd_i,
    output logic            carrier_o
);
    localparam int DIV_W = MD_W + 2;

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic             car;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic [DIV_W-1:0] n_div, lim, hi2;

    always_comb begin
        // reference divisor MD+2; in ticks the period is twice that
        n_div = DIV_W'(md_i) + DIV_W'(2);
        lim   = n_div << 1;
        hi2   = ((n_div + DIV_W'(1)) >> 1) << 1;
        st_d  = st_q;
        if (txd_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim - DIV_W'(1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        st_d.car = !txd_i && (st_d.cnt < hi2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carrier_o = st_q.car;

    p_idle_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txd_i |=> !carrier_o);
    p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!txd_i && !st_q.run) |=> (carrier_o && st_q.cnt == '0));
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !txd_i && st_q.cnt >= lim - DIV_W'(1)) |=> (st_q.cnt == '0));
endmodule

// File: rtl/ask_rx_sync.sv
`timescale 1ns/1ps
module ask_rx_sync
    import ask_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic rise_o
);
    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
    } sy_st_t;

    sy_st_t st_d, st_q;

    always_comb begin
        st_d.sh = {st_q.sh[SYNC_STAGES-1:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // last synchronized sample high, the one before it low
    assign rise_o = st_q.sh[SYNC_STAGES-1] && !st_q.sh[SYNC_STAGES];

    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ask_rx_window.sv
`timescale 1ns/1ps
module ask_rx_window
    import ask_pkg::*;
#(
    parameter int MD_W   = 8,
    parameter int RATS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MD_W-1:0]   md_i,
    input  logic [RATS_W-1:0] rats_i,
    input  logic              rise_i,
    output logic              ok_o
);
    localparam int PER_MAX = 2 * ((1 << MD_W) - 1) + 3 + 6 * (1 << RATS_W);
    localparam int PER_W   = $clog2(PER_MAX + 2);

    typedef struct packed {
        logic             armed;
        logic [PER_W-1:0] per;
        hit_e             hit;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic [PER_W-1:0] mdx, rx, tmin, tmax, meas;
    logic             in_win;

    always_comb begin
        mdx    = PER_W'(md_i);
        rx     = PER_W'(rats_i);
        tmin   = (mdx << 1) + PER_W'(3) + rx;
        tmax   = (mdx << 1) + PER_W'(3) + PER_W'(6) * (rx + PER_W'(1));
        meas   = st_q.per + PER_W'(1);
        in_win = (meas >= tmin) && (meas <= tmax);
        st_d   = st_q;
        if (rise_i) begin
            st_d.per = '0;
            if (!st_q.armed) begin
                st_d.armed = 1'b1;
            end else if (in_win) begin
                st_d.hit = (st_q.hit == HIT_NONE) ? HIT_ONE : HIT_LOCK;
            end else begin
                st_d.hit = HIT_NONE;
            end
        end else if (st_q.armed && st_q.per >= tmax) begin
            st_d.armed = 1'b0;
            st_d.per   = '0;
            st_d.hit   = HIT_NONE;
        end else if (st_q.armed) begin
            st_d.per = meas;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b0;
            st_q.per   <= '0;
            st_q.hit   <= HIT_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ok_o = (st_q.hit == HIT_LOCK);

    p_lock_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> st_q.armed);
    p_lock_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_o) |-> $past(rise_i));
    p_first_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !st_q.armed) |=> !ok_o);
    p_out_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && st_q.armed && !in_win) |=> !ok_o);
    p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !rise_i && st_q.per >= tmax) |=> (!st_q.armed && !ok_o));
endmodule

// File: rtl/ask_carrier_unit.sv
`timescale 1ns/1ps
module ask_carrier_unit #(
    parameter int MD_W   = 8,
    parameter int RATS_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MD_W-1:0]   md_i,
    input  logic [RATS_W-1:0] rats_i,
    input  logic              txd_i,
    input  logic              rx_edge_i,
    output logic              carrier_o,
    output logic              carrier_ok_o
);
    logic rise;

    ask_tx_div #(.MD_W(MD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .md_i      (md_i),
        .txd_i     (txd_i),
        .carrier_o (carrier_o)
    );

    ask_rx_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (rx_edge_i),
        .rise_o (rise)
    );

    ask_rx_window #(.MD_W(MD_W), .RATS_W(RATS_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .md_i   (md_i),
        .rats_i (rats_i),
        .rise_i (rise),
        .ok_o   (carrier_ok_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!carrier_o && !carrier_ok_o));
endmodule

// File: tb/sim_ask_carrier_unit.sv
`timescale 1ns/1ps
module sim_ask_carrier_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] md = 8'd5;
    logic [2:0] rats = 3'd0;
    logic       txd = 1'b1;
    logic       raw = 1'b0;
    logic       car, ok;

    int    errors = 0;
    int    checks = 0;
    string phase = "R1";

    // model state
    int m_run, m_t, m_car;
    int h1, h2, h3, k, last, m_armed, m_hits, m_ok;

    always #2.5 clk = ~clk;

    ask_carrier_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .md_i         (md),
        .rats_i       (rats),
        .txd_i        (txd),
        .rx_edge_i    (raw),
        .carrier_o    (car),
        .carrier_ok_o (ok)
    );

    task automatic chk(input logic got, input logic exp, input string tag, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // behavioural reference, indexed by clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_t = 0; m_car = 0;
            h1 = 0; h2 = 0; h3 = 0; k = 0; last = 0;
            m_armed = 0; m_hits = 0; m_ok = 0;
        end else begin
            int n, tmin, tmax, rise;
            k++;
            n = int'(md) + 2;
            if (txd) begin
                m_run = 0;
                m_car = 0;
            end else begin
                if (m_run == 0) begin m_run = 1; m_t = 0; end
                else m_t++;
                m_car = ((m_t % (2 * n)) < 2 * ((n + 1) / 2)) ? 1 : 0;
            end
            rise = (h2 == 1 && h3 == 0) ? 1 : 0;
            h3 = h2; h2 = h1; h1 = int'(raw);
            tmin = 2 * int'(md) + 3 + int'(rats);
            tmax = 2 * int'(md) + 3 + 6 * (int'(rats) + 1);
            if (rise == 1) begin
                if (m_armed == 0) begin
                    m_armed = 1;
                end else if ((k - last) >= tmin && (k - last) <= tmax) begin
                    m_hits = (m_hits < 2) ? m_hits + 1 : 2;
                end else begin
                    m_hits = 0;
                end
                last = k;
            end else if (m_armed == 1 && (k - last) > tmax) begin
                m_armed = 0;
                m_hits = 0;
            end
            m_ok = (m_hits == 2) ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && k > 0) begin
            chk(car, m_car[0], phase, "carrier_o vs model");
            chk(ok, m_ok[0], phase, "carrier_ok_o vs model");
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int d, input int n);
        for (int i = 0; i < n; i++) begin
            raw = 1'b1;
            ticks(d / 2);
            raw = 1'b0;
            ticks(d - d / 2);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hung expected finished");
        finish_run();
    end

    initial begin
        ticks(3);
        chk(car, 1'b0, "R1", "carrier_o in reset");
        chk(ok, 1'b0, "R1", "carrier_ok_o in reset");
        rst_n = 1'b1;
        ticks(1);
        chk(car, 1'b0, "R1", "carrier_o after reset");
        chk(ok, 1'b0, "R1", "carrier_ok_o after reset");

        // transmit: default divider, then even and odd divisors
        phase = "R3";
        txd = 1'b0;
        ticks(1);
        chk(car, 1'b1, "R3", "carrier high first tick");
        ticks(60);
        txd = 1'b1;
        ticks(3);
        chk(car, 1'b0, "R2", "carrier idle with txd high");
        phase = "R2";
        md = 8'd0;
        ticks(2);
        phase = "R4";
        txd = 1'b0;
        ticks(20);
        txd = 1'b1;
        ticks(2);
        md = 8'd6;
        txd = 1'b0;
        ticks(40);
        txd = 1'b1;
        ticks(2);
        md = 8'd1;
        txd = 1'b0;
        ticks(30);
        txd = 1'b1;
        ticks(2);
        chk(car, 1'b0, "R2", "carrier dark after odd run");
        md = 8'd5;
        ticks(4);

        // receive, window 13..19
        phase = "R5";
        pulses(14, 5);
        chk(ok, 1'b1, "R7", "lock at period 14");
        phase = "R9";
        ticks(45);
        chk(ok, 1'b0, "R9", "cleared by silence");
        phase = "R10";
        pulses(13, 5);
        chk(ok, 1'b1, "R10", "lower bound 13 accepted");
        ticks(45);
        pulses(19, 5);
        chk(ok, 1'b1, "R10", "upper bound 19 accepted");
        ticks(45);
        phase = "R8";
        pulses(12, 5);
        chk(ok, 1'b0, "R8", "period 12 rejected");
        ticks(45);
        pulses(14, 4);
        chk(ok, 1'b1, "R7", "lock before glitch");
        pulses(9, 1);
        pulses(14, 1);
        chk(ok, 1'b0, "R8", "short period drops lock");
        ticks(45);

        // receive with tolerance 2: window 15..31
        phase = "R6";
        rats = 3'd2;
        pulses(31, 5);
        chk(ok, 1'b1, "R6", "period 31 in widened window");
        ticks(80);
        pulses(32, 5);
        chk(ok, 1'b0, "R6", "period 32 beyond window");
        ticks(80);
        md = 8'd10;
        rats = 3'd1;
        pulses(24, 4);
        chk(ok, 1'b1, "R6", "md 10 lower bound 24");
        phase = "R9";
        ticks(80);
        chk(ok, 1'b0, "R9", "timeout after md 10 train");
        finish_run();
    end
endmodule